// File: doc/BRIEF.md
# Dual-Channel Converter Output Stage

This block sits between the back end of a two-channel pipelined converter and the chip's parallel output pads. Each clock it can take one 10-bit offset-binary sample per channel, carry the pair through a fixed-latency pipeline and present it on two parallel buses. Both buses are loaded by the same clock edge. A format pin picks offset-binary or two's-complement coding. A disable pin turns off the per-bit pad drive enables.

Two power inputs govern acceptance. The light-sleep input stops new samples from entering, but lets samples already in flight drain to the outputs. The power-down input freezes the output word at once and discards everything in flight. After power-down is released, the outputs stay frozen until a sample taken after the release has crossed the whole latency.

Top module: `dual_adc_out_ctrl`

## Requirements
- R1: A sample pair presented at rising edge k, with both power inputs low, appears on the data outputs at edge k+LATENCY (5 by default) and not earlier.
- R2: With `fmt_twos_i` low (offset binary), the output word equals the input sample bit for bit: 0x3FF stays 0x3FF, 0x200 stays 0x200 and 0x000 stays 0x000.
- R3: With `fmt_twos_i` high (two's complement), the output is the sample with its MSB (bit 9) inverted: 0x3FF gives 0x1FF, 0x200 gives 0x000 and 0x000 gives 0x200.
- R4: Channel A and channel B outputs change on the same clock edge for a pair taken on the same edge.
- R5: `out_dis_i` high drives all bits of both drive-enable buses to 0 in the same cycle. Low drives them all to 1.
- R6: While `pwr_dn_i` is high, both data outputs hold the word present just before power-down, and samples in flight are discarded.
- R7: After `pwr_dn_i` falls, the outputs do not change until a sample accepted at or after the release edge has passed the full LATENCY.
- R8: While `sleep_i` is high, no new sample is accepted. Samples taken before sleep still reach the outputs, and after that the outputs hold.
- R9: The coding is applied when a word is loaded. Changing `fmt_twos_i` while the outputs are held does not change them.
- R10: A synchronous active-high reset clears both data outputs to 0 and empties the pipeline.
- R11: Toggling `out_dis_i` does not alter the words on the data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_a_i | input | 10 | Channel A offset-binary sample |
| smp_b_i | input | 10 | Channel B offset-binary sample |
| fmt_twos_i | input | 1 | 1 selects two's complement, 0 offset binary |
| out_dis_i | input | 1 | 1 turns off all pad drive enables |
| pwr_dn_i | input | 1 | Power-down: freeze outputs, flush pipeline |
| sleep_i | input | 1 | Light sleep: stop accepting samples |
| dout_a_o | output | 10 | Channel A output word |
| dout_b_o | output | 10 | Channel B output word |
| drv_en_a_o | output | 10 | Per-bit pad drive enables, channel A |
| drv_en_b_o | output | 10 | Per-bit pad drive enables, channel B |

## Verification
The bench builds the block with its defaults: a 10-bit sample width and a latency of 5. Ten bits let the full-scale endpoints and the mid-scale code be driven in both codings, so the MSB inversion is tested at its edges. A five-stage pipeline leaves room to start a power-down or a sleep while a sample sits partway through. The bench can then tell a flush apart from a drain, and see whether an early release of the frozen outputs happens.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;

    parameter int SAMP_W = 10;

    typedef logic [SAMP_W-1:0] samp_t;

    typedef enum logic {
        CODE_OFFSET = 1'b0,
        CODE_TWOS   = 1'b1
    } code_e;

    typedef struct packed {
        logic  vld;
        samp_t ch_a;
        samp_t ch_b;
    } pair_t;

    // Offset binary to two's complement differs only in the sign bit.
    function automatic samp_t recode(samp_t raw, code_e mode);
        samp_t res;
        res = raw;
        if (mode == CODE_TWOS) begin
            res[SAMP_W-1] = ~raw[SAMP_W-1];
        end
        return res;
    endfunction

endpackage

// File: rtl/adc_pair_pipe.sv
module adc_pair_pipe
    import adc_out_pkg::*;
#(
    parameter int DEPTH = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  flush,
    input  samp_t in_a,
    input  samp_t in_b,
    output pair_t tail
);

    logic [DEPTH-1:0] vld_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stg
        pair_t q;

        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    q <= '0;
                end else begin
                    q.vld <= accept;
                    if (accept) begin
                        q.ch_a <= in_a;
                        q.ch_b <= in_b;
                    end
                end
            end

            AST_NO_ACCEPT_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
                !accept |=> !q.vld); // R8
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    q <= '0;
                end else begin
                    q <= g_stg[g-1].q;
                end
            end
        end

        assign vld_vec[g] = q.vld;
    end

    assign tail = g_stg[DEPTH-1].q;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> ($countones(vld_vec) == 0)); // R6

endmodule

// File: rtl/adc_out_reg.sv
module adc_out_reg
    import adc_out_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_e mode,
    input  pair_t src,
    output samp_t q_a,
    output samp_t q_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_a <= '0;
            q_b <= '0;
        end else if (load) begin
            q_a <= recode(src.ch_a, mode);
            q_b <= recode(src.ch_b, mode);
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(q_a) && $stable(q_b))); // R6

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        (load && mode == CODE_OFFSET) |=> (q_a == $past(src.ch_a) && q_b == $past(src.ch_b))); // R2

    AST_TWOS_SIGN: assert property (@(posedge clk) disable iff (rst)
        (load && mode == CODE_TWOS) |=> (q_a[SAMP_W-1] != $past(src.ch_a[SAMP_W-1]))); // R3

endmodule

// File: rtl/adc_drive_ctl.sv
module adc_drive_ctl #(
    parameter int W = 10
) (
    input  logic         out_dis,
    output logic [W-1:0] en_a,
    output logic [W-1:0] en_b
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign en_a[i] = ~out_dis;
        assign en_b[i] = ~out_dis;
    end

endmodule

// File: rtl/dual_adc_out_ctrl.sv
module dual_adc_out_ctrl
    import adc_out_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] smp_a_i,
    input  logic [SAMP_W-1:0] smp_b_i,
    input  logic              fmt_twos_i,
    input  logic              out_dis_i,
    input  logic              pwr_dn_i,
    input  logic              sleep_i,
    output logic [SAMP_W-1:0] dout_a_o,
    output logic [SAMP_W-1:0] dout_b_o,
    output logic [SAMP_W-1:0] drv_en_a_o,
    output logic [SAMP_W-1:0] drv_en_b_o
);

    localparam int PIPE_DEPTH = LATENCY;
    localparam int CNT_W      = $clog2(LATENCY + 1);

    logic  accept;
    logic  load;
    pair_t tail;
    code_e mode;

    assign accept = ~sleep_i & ~pwr_dn_i;
    assign load   = tail.vld & ~pwr_dn_i;
    assign mode   = code_e'(fmt_twos_i);

    adc_pair_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .flush  (pwr_dn_i),
        .in_a   (smp_a_i),
        .in_b   (smp_b_i),
        .tail   (tail)
    );

    adc_out_reg u_oreg (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .mode (mode),
        .src  (tail),
        .q_a  (dout_a_o),
        .q_b  (dout_b_o)
    );

    adc_drive_ctl #(.W(SAMP_W)) u_drv (
        .out_dis (out_dis_i),
        .en_a    (drv_en_a_o),
        .en_b    (drv_en_b_o)
    );

    // Cycles since the last power-down (or reset), saturating at LATENCY.
    logic [CNT_W-1:0] since_pd;

    always_ff @(posedge clk) begin
        if (rst || pwr_dn_i) begin
            since_pd <= '0;
        end else if (since_pd != CNT_W'(LATENCY)) begin
            since_pd <= since_pd + 1'b1;
        end
    end

    AST_PD_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (since_pd < CNT_W'(LATENCY)) |=> ($stable(dout_a_o) && $stable(dout_b_o))); // R7

    AST_PD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        pwr_dn_i |=> ($stable(dout_a_o) && $stable(dout_b_o))); // R6

    AST_EN_POLARITY: assert property (@(posedge clk) disable iff (rst)
        out_dis_i |-> (drv_en_a_o == '0 && drv_en_b_o == '0)); // R5

    AST_EN_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (drv_en_a_o == drv_en_b_o) && ($countones(drv_en_a_o) == 0 || $countones(drv_en_a_o) == SAMP_W)); // R5

endmodule

// File: tb/dual_adc_out_ctrl_tb.sv
module dual_adc_out_ctrl_tb;

    localparam int LAT = 5;
    localparam int W   = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] smp_a = '0;
    logic [W-1:0] smp_b = '0;
    logic         fmt = 1'b0;
    logic         odis = 1'b0;
    logic         pd = 1'b0;
    logic         slp = 1'b0;
    logic [W-1:0] dout_a, dout_b, en_a, en_b;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dual_adc_out_ctrl #(.LATENCY(LAT)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .smp_a_i    (smp_a),
        .smp_b_i    (smp_b),
        .fmt_twos_i (fmt),
        .out_dis_i  (odis),
        .pwr_dn_i   (pd),
        .sleep_i    (slp),
        .dout_a_o   (dout_a),
        .dout_b_o   (dout_b),
        .drv_en_a_o (en_a),
        .drv_en_b_o (en_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a pair and wait until it has certainly reached the outputs.
    task automatic settle(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        smp_a = a;
        smp_b = b;
        repeat (LAT + 2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 dout_a after reset", dout_a, 0);
        check("R10 dout_b after reset", dout_b, 0);
        check("R5 enables on after reset", en_a, 10'h3FF);
    endtask

    task automatic t_latency;
        fmt = 1'b0;
        settle(10'h155, 10'h2AA);
        smp_a = 10'h0F0;
        smp_b = 10'h30F;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        check("R1 dout_a not early", dout_a, 10'h155);
        check("R4 dout_b not early", dout_b, 10'h2AA);
        @(posedge clk);
        @(negedge clk);
        check("R1 dout_a at latency", dout_a, 10'h0F0);
        check("R4 dout_b same edge", dout_b, 10'h30F);
    endtask

    task automatic t_offset;
        fmt = 1'b0;
        settle(10'h3FF, 10'h000);
        check("R2 offset +FS", dout_a, 10'h3FF);
        check("R2 offset -FS", dout_b, 10'h000);
        settle(10'h200, 10'h1FF);
        check("R2 offset zero", dout_a, 10'h200);
        check("R2 offset below zero", dout_b, 10'h1FF);
    endtask

    task automatic t_twos;
        fmt = 1'b1;
        settle(10'h3FF, 10'h000);
        check("R3 twos +FS", dout_a, 10'h1FF);
        check("R3 twos -FS", dout_b, 10'h200);
        settle(10'h200, 10'h201);
        check("R3 twos zero", dout_a, 10'h000);
        check("R3 twos +1", dout_b, 10'h001);
        fmt = 1'b0;
    endtask

    task automatic t_oe;
        settle(10'h2C3, 10'h13C);
        odis = 1'b1;
        #1;
        check("R5 enables A off", en_a, 0);
        check("R5 enables B off", en_b, 0);
        check("R11 dout_a kept while disabled", dout_a, 10'h2C3);
        check("R11 dout_b kept while disabled", dout_b, 10'h13C);
        @(negedge clk);
        odis = 1'b0;
        #1;
        check("R5 enables A on", en_a, 10'h3FF);
        check("R5 enables B on", en_b, 10'h3FF);
    endtask

    task automatic t_powerdown;
        fmt = 1'b0;
        settle(10'h111, 10'h222);
        smp_a = 10'h333;
        smp_b = 10'h044;
        repeat (2) @(posedge clk);
        @(negedge clk);
        pd  = 1'b1;
        fmt = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 dout_a frozen", dout_a, 10'h111);
        check("R6 dout_b frozen", dout_b, 10'h222);
        check("R9 format change ignored while held", dout_a, 10'h111);
        pd    = 1'b0;
        fmt   = 1'b0;
        smp_a = 10'h0AB;
        smp_b = 10'h0CD;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        check("R7 still frozen before latency", dout_a, 10'h111);
        check("R7 flushed sample never shown", dout_b, 10'h222);
        @(posedge clk);
        @(negedge clk);
        check("R7 fresh A after latency", dout_a, 10'h0AB);
        check("R7 fresh B after latency", dout_b, 10'h0CD);
    endtask

    task automatic t_sleep;
        settle(10'h100, 10'h101);
        smp_a = 10'h1F0;
        smp_b = 10'h1F1;
        @(posedge clk);
        @(negedge clk);
        slp   = 1'b1;
        smp_a = 10'h0EE;
        smp_b = 10'h0EF;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        check("R8 in-flight not yet out", dout_a, 10'h100);
        @(posedge clk);
        @(negedge clk);
        check("R8 in-flight drains A", dout_a, 10'h1F0);
        check("R8 in-flight drains B", dout_b, 10'h1F1);
        repeat (LAT + 2) @(posedge clk);
        @(negedge clk);
        check("R8 no sample accepted in sleep A", dout_a, 10'h1F0);
        check("R8 no sample accepted in sleep B", dout_b, 10'h1F1);
        slp = 1'b0;
    endtask

    initial begin
        t_reset();
        t_latency();
        t_offset();
        t_twos();
        t_oe();
        t_powerdown();
        t_sleep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule